// File: doc/BRIEF.md
# Protection Input Conditioner

This block takes one protection signal for a PWM output stage and turns it into actions the stage obeys. Two sources can feed it: a device pin and an on-chip comparator output. Both sources are brought into the PWM clock domain by a two-flop synchronizer.

Two independent configuration sets, A (index 0) and B (index 1), read the same synchronized sources. Each set has its own controls:
- a source choice;
- an optional four-sample noise filter;
- a polarity;
- a choice between edge and level detection;
- a 4-bit action code;
- an asynchronous override enable.

The action code selects one of four behaviours: nothing, a counter-retrigger request, a latched shutdown, or a shutdown that lasts while the input is active. The asynchronous override gates the output enable directly from the raw, unsynchronized input. It therefore protects the stage even when the PWM clock has stopped. The clocked path keeps working alongside it.

The output enable is the only gate the PWM stage needs. It is high when the outputs may drive and low when any set demands a shutdown.

Top module: `prot_in_cond`

## Requirements
- R1: After reset, `out_en` is 1 and `retrig` is 0, and both sets behave as disabled until configured.
- R2: `src_sel[s]`=0 makes set s watch `pin_in`; `src_sel[s]`=1 makes it watch `cmp_in`. The unselected source has no effect on that set.
- R3: With the filter off, a change on the selected input that is driven between two clock edges becomes visible at the outputs two rising edges later.
- R4: With `filt_en[s]`=1, the filtered level changes only after 4 consecutive equal synchronized samples. A pulse shorter than 4 cycles is ignored. A lasting change appears six rising edges after it is driven.
- R5: `pol_low[s]`=0 means the input is active when high; `pol_low[s]`=1 means it is active when low.
- R6: `edge_sel[s]`=1 gives a one-cycle event on the inactive-to-active transition. `edge_sel[s]`=0 gives an event for every cycle the input is active.
- R7: Action code 1 (retrigger) drives `retrig[s]` high for each event cycle and leaves `out_en` at 1.
- R8: Action code 2 (fault latch) drives `out_en` low from the first event cycle. It stays low after the input returns inactive, until a `latch_clr[s]` pulse. `out_en` returns high one edge after the clear is sampled.
- R9: Action code 3 (fault level) drives `out_en` low exactly during event cycles.
- R10: Action code 0 and all codes from 4 to 15 are disabled: no retrigger and no shutdown.
- R11: With `async_en[s]`=1 and action code 2 or 3, the raw selected input at its active level drives `out_en` low combinationally, without any clock edge. With `async_en[s]`=0, no such path exists.
- R12: When a latch event and `latch_clr[s]` are sampled on the same edge, the latch is set.
- R13: The two sets act independently. `out_en` is low if either set demands a shutdown. Both sets may respond to the same input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | External protection pin |
| cmp_in | input | 1 | On-chip comparator output |
| src_sel | input | 2 | Per-set source choice (1 = comparator) |
| filt_en | input | 2 | Per-set four-sample filter enable |
| pol_low | input | 2 | Per-set active-low polarity |
| edge_sel | input | 2 | Per-set edge detection (0 = level) |
| async_en | input | 2 | Per-set asynchronous override enable |
| mode_cfg | input | 8 | Action codes; set s uses bits [4s+3:4s] |
| latch_clr | input | 2 | Per-set fault latch clear |
| retrig | output | 2 | Per-set counter retrigger request |
| out_en | output | 1 | High when PWM outputs may drive |

## Verification
Two actions can fall in the same cycle: set A's retrigger and set B's level shutdown fed by the same pin. The bench provokes this by raising the pin with A in retrigger mode and B in fault-level mode. It expects `retrig`=01 together with `out_en`=0 two edges later. A second collision pairs a latch event with a software clear sampled on the same edge. It is timed so that the event lasts only that one cycle, and it is judged by `out_en` staying low on the following cycles.

// File: rtl/fic_pkg.sv
`timescale 1ns/1ps
package fic_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] ACT_RETRIG = 4'd1;
  localparam logic [MODE_W-1:0] ACT_LATCH  = 4'd2;
  localparam logic [MODE_W-1:0] ACT_LEVEL  = 4'd3;

  // Level after polarity: 1 means the protection condition is present
  function automatic logic active_level(input logic lvl, input logic act_low);
    return lvl ^ act_low;
  endfunction

  function automatic logic is_shutdown_code(input logic [MODE_W-1:0] code);
    return (code == ACT_LATCH) || (code == ACT_LEVEL);
  endfunction
endpackage

// File: rtl/fic_sync.sv
`timescale 1ns/1ps
module fic_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fic_filter.sv
`timescale 1ns/1ps
module fic_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s,
  output logic q
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist;
  logic          held;
  logic          agree;

  // True when the current sample matches every remembered sample
  function automatic logic samples_agree(input logic cur, input logic [HW-1:0] h);
    return h == {HW{cur}};
  endfunction

  assign agree = samples_agree(s, hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      held <= 1'b0;
    end else begin
      if (HW > 1) hist <= {hist[HW-2:0], s};
      else        hist <= s;
      if (agree) held <= s;
    end
  end

  assign q = en ? held : s;
endmodule

// File: rtl/fic_detect.sv
`timescale 1ns/1ps
module fic_detect
  import fic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic act_low,
  input  logic edge_sel,
  output logic evt
);
  logic act_now;
  logic act_prev;

  assign act_now = active_level(lvl, act_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b0;
    else        act_prev <= act_now;
  end

  assign evt = edge_sel ? (act_now & ~act_prev) : act_now;

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && evt) |=> (!edge_sel || !evt)); // R6
endmodule

// File: rtl/fic_action.sv
`timescale 1ns/1ps
module fic_action
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [MODE_W-1:0] code,
  input  logic              clr,
  output logic              retrig,
  output logic              shutdown
);
  logic latch_q;
  logic latch_set;
  logic level_hit;

  assign retrig    = evt & (code == ACT_RETRIG);
  assign latch_set = evt & (code == ACT_LATCH);
  assign level_hit = evt & (code == ACT_LEVEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= 1'b0;
    else if (latch_set) latch_q <= 1'b1;
    else if (clr)       latch_q <= 1'b0;
  end

  assign shutdown = latch_q | latch_set | level_hit;

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr) |=> latch_q); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_set && clr) |=> latch_q); // R12
endmodule

// File: rtl/prot_in_cond.sv
`timescale 1ns/1ps
module prot_in_cond
  import fic_pkg::*;
#(
  parameter int N_SETS      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pin_in,
  input  logic                     cmp_in,
  input  logic [N_SETS-1:0]        src_sel,
  input  logic [N_SETS-1:0]        filt_en,
  input  logic [N_SETS-1:0]        pol_low,
  input  logic [N_SETS-1:0]        edge_sel,
  input  logic [N_SETS-1:0]        async_en,
  input  logic [N_SETS*MODE_W-1:0] mode_cfg,
  input  logic [N_SETS-1:0]        latch_clr,
  output logic [N_SETS-1:0]        retrig,
  output logic                     out_en
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0]  raw;
  logic [N_SRC-1:0]  synced;
  logic [N_SETS-1:0] shut;
  logic [N_SETS-1:0] async_kill;

  assign raw = {cmp_in, pin_in};

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    fic_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[k]), .q(synced[k])
    );
  end

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic              picked;
    logic              cleaned;
    logic              evt;
    logic [MODE_W-1:0] code;

    assign code   = mode_cfg[s*MODE_W +: MODE_W];
    assign picked = src_sel[s] ? synced[1] : synced[0];

    fic_filter #(.LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(filt_en[s]), .s(picked), .q(cleaned)
    );

    fic_detect u_det (
      .clk(clk), .rst_n(rst_n), .lvl(cleaned), .act_low(pol_low[s]),
      .edge_sel(edge_sel[s]), .evt(evt)
    );

    fic_action u_act (
      .clk(clk), .rst_n(rst_n), .evt(evt), .code(code), .clr(latch_clr[s]),
      .retrig(retrig[s]), .shutdown(shut[s])
    );

    // Raw path: no synchronizer, no filter, no clock
    assign async_kill[s] = async_en[s] & is_shutdown_code(code)
                         & active_level(src_sel[s] ? raw[1] : raw[0], pol_low[s]);
  end

  assign out_en = ~(|shut) & ~(|async_kill);

  AST_ASYNC_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (|async_kill) |-> !out_en); // R11
endmodule

// File: tb/prot_in_cond_test.sv
`timescale 1ns/1ps
module prot_in_cond_test;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0, cmp_in = 1'b0;
  logic [1:0] src_sel = '0, filt_en = '0, pol_low = '0, edge_sel = '0;
  logic [1:0] async_en = '0, latch_clr = '0;
  logic [7:0] mode_cfg = '0;
  logic [1:0] retrig;
  logic       out_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         when;
    string      tag;
    logic       oe;
    logic [1:0] rt;
  } exp_t;
  exp_t sb[$];

  prot_in_cond uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_sel(src_sel), .filt_en(filt_en), .pol_low(pol_low),
    .edge_sel(edge_sel), .async_en(async_en), .mode_cfg(mode_cfg),
    .latch_clr(latch_clr), .retrig(retrig), .out_en(out_en)
  );

  initial forever begin
    #2;
    if (clk_run) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].when == cyc) begin
        checks++;
        if (out_en !== sb[i].oe || retrig !== sb[i].rt) begin
          errors++;
          $display("FAIL %s cyc %0d: out_en=%b retrig=%b expected out_en=%b retrig=%b",
                   sb[i].tag, cyc, out_en, retrig, sb[i].oe, sb[i].rt);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic expect_at(input int ofs, input string tag, input logic oe,
                           input logic [1:0] rt);
    exp_t e;
    e.when = cyc + ofs;
    e.tag  = tag;
    e.oe   = oe;
    e.rt   = rt;
    sb.push_back(e);
  endtask

  task automatic direct(input string tag, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: out_en=%b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    direct("R1 out_en after reset", out_en, 1'b1);
    checks++;
    if (retrig !== 2'b00) begin
      errors++;
      $display("FAIL R1 retrig=%b expected 00", retrig);
    end
    expect_at(1, "R1", 1'b1, 2'b00);
    tick(3);

    // R3, R6, R7: edge retrigger, filter off
    mode_cfg[3:0] = 4'd1; edge_sel[0] = 1'b1;
    tick(3);
    pin_in = 1'b1;
    expect_at(1, "R3", 1'b1, 2'b00);
    expect_at(2, "R7", 1'b1, 2'b01);
    expect_at(3, "R6", 1'b1, 2'b00);
    expect_at(4, "R6", 1'b1, 2'b00);
    tick(5); pin_in = 1'b0; tick(4);

    // R6: level retrigger lasts while active
    edge_sel[0] = 1'b0;
    tick(3);
    pin_in = 1'b1;
    expect_at(1, "R3", 1'b1, 2'b00);
    for (int k = 2; k <= 4; k++) expect_at(k, "R6", 1'b1, 2'b01);
    expect_at(5, "R6", 1'b1, 2'b00);
    tick(3); pin_in = 1'b0; tick(5);

    // R4: filter ignores a 3-cycle pulse, passes a lasting change after 6 edges
    filt_en[0] = 1'b1;
    tick(8);
    pin_in = 1'b1;
    for (int k = 1; k <= 10; k++) expect_at(k, "R4", 1'b1, 2'b00);
    tick(3); pin_in = 1'b0; tick(10);
    pin_in = 1'b1;
    expect_at(5, "R4", 1'b1, 2'b00);
    expect_at(6, "R4", 1'b1, 2'b01);
    tick(10);
    pin_in = 1'b0;
    expect_at(5, "R4", 1'b1, 2'b01);
    expect_at(6, "R4", 1'b1, 2'b00);
    tick(8);
    filt_en[0] = 1'b0; mode_cfg[3:0] = 4'd0;
    tick(4);

    // R5, R9: active-low level shutdown
    pol_low[0] = 1'b1; pin_in = 1'b1;
    tick(4);
    mode_cfg[3:0] = 4'd3;
    tick(3);
    pin_in = 1'b0;
    expect_at(1, "R5", 1'b1, 2'b00);
    expect_at(2, "R5", 1'b0, 2'b00);
    expect_at(3, "R9", 1'b0, 2'b00);
    tick(4);
    pin_in = 1'b1;
    expect_at(1, "R9", 1'b0, 2'b00);
    expect_at(2, "R9", 1'b1, 2'b00);
    tick(3);
    mode_cfg[3:0] = 4'd0; pin_in = 1'b0; pol_low[0] = 1'b0;
    tick(4);

    // R8: latched shutdown persists until cleared
    mode_cfg[3:0] = 4'd2;
    tick(3);
    pin_in = 1'b1;
    for (int k = 2; k <= 6; k++) expect_at(k, "R8", 1'b0, 2'b00);
    tick(1); pin_in = 1'b0;
    tick(6);
    latch_clr[0] = 1'b1;
    expect_at(1, "R8", 1'b1, 2'b00);
    tick(1); latch_clr[0] = 1'b0;
    tick(3);

    // R12: set and clear on the same edge, set wins
    pin_in = 1'b1;
    for (int k = 2; k <= 5; k++) expect_at(k, "R12", 1'b0, 2'b00);
    tick(1); pin_in = 1'b0;
    tick(1); latch_clr[0] = 1'b1;
    tick(1); latch_clr[0] = 1'b0;
    tick(3);
    latch_clr[0] = 1'b1;
    expect_at(1, "R12", 1'b1, 2'b00);
    tick(1); latch_clr[0] = 1'b0;
    tick(3);

    // R2: source select, unselected pin ignored
    mode_cfg[3:0] = 4'd3; src_sel[0] = 1'b1;
    tick(3);
    pin_in = 1'b1;
    for (int k = 1; k <= 4; k++) expect_at(k, "R2", 1'b1, 2'b00);
    tick(5); pin_in = 1'b0;
    cmp_in = 1'b1;
    expect_at(2, "R2", 1'b0, 2'b00);
    tick(3); cmp_in = 1'b0;
    expect_at(2, "R2", 1'b1, 2'b00);
    tick(4);
    src_sel[0] = 1'b0;

    // R10: reserved codes do nothing
    mode_cfg[3:0] = 4'd7;
    tick(3);
    pin_in = 1'b1;
    expect_at(2, "R10", 1'b1, 2'b00);
    expect_at(3, "R10", 1'b1, 2'b00);
    tick(4); pin_in = 1'b0;
    mode_cfg[3:0] = 4'd15;
    tick(3);
    pin_in = 1'b1;
    expect_at(3, "R10", 1'b1, 2'b00);
    tick(4); pin_in = 1'b0;
    tick(3);

    // R13: A retriggers and B shuts down in the same cycle
    mode_cfg = {4'd3, 4'd1};
    tick(3);
    pin_in = 1'b1;
    expect_at(2, "R13", 1'b0, 2'b01);
    tick(3); pin_in = 1'b0;
    expect_at(2, "R13", 1'b1, 2'b00);
    tick(4);
    src_sel[1] = 1'b1;
    tick(3);
    cmp_in = 1'b1;
    expect_at(2, "R13", 1'b0, 2'b00);
    tick(3); cmp_in = 1'b0;
    expect_at(2, "R13", 1'b1, 2'b00);
    tick(4);
    mode_cfg = '0; src_sel = '0;
    tick(3);

    // R11: asynchronous override with the clock stopped
    mode_cfg[3:0] = 4'd3; async_en[0] = 1'b1;
    tick(3);
    clk_run = 1'b0;
    #5 pin_in = 1'b1;
    #1 direct("R11 async forces off", out_en, 1'b0);
    pin_in = 1'b0;
    #1 direct("R11 async release", out_en, 1'b1);
    async_en[0] = 1'b0;
    pin_in = 1'b1;
    #1 direct("R11 no async path when disabled", out_en, 1'b1);
    pin_in = 1'b0;
    #1 clk_run = 1'b1;
    tick(4);
    mode_cfg = '0;
    tick(3);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations never compared", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule